// File: doc/BRIEF.md
# LCD Controller Register Bank

This block is the software-visible register file of a color LCD controller. A host on a simple 32-bit bus reads and writes it with separate read and write strobes and a byte offset. It holds four timing words, the base addresses of the upper and lower panel frames, a control word and an interrupt mask. It also serves a raw interrupt status, a masked status and a write-only clear register. A window at the top of the address space returns fixed identification bytes.

Besides the bus, the block drives the panel geometry decoded from the timing words: a column count and a row count. It also drives the pixel depth and the two byte-ordering selects taken from the control word. The display enable output is high only when both the enable bit and the power bit of the control word are set. A one-cycle resize pulse tells the downstream video logic to re-read the geometry.

Pixel fetching, palette storage and video timing generation are handled elsewhere.

Top module: `lcdc_regs`

## Requirements
- R1: The word index is `addr[11:2]`. Indices 0 to 3 are timing words, 4 is the upper base, 5 is the lower base, 6 is the interrupt mask (low 4 bits, zero-extended on read) and 7 is control. Each is writable, and a read returns the last written value on `rdata` one cycle after `rd_en`.
- R2: Byte offsets 0xFE0 to 0xFFC read, one byte per word in rising address order, 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R3: `disp_en` is 1 exactly when control bit 0 and control bit 11 are both 1.
- R4: `cols` equals 16 × (timing0 bits 7:2 + 1), and `rows` equals timing1 bits 9:0 + 1. Both follow a write in the cycle after it.
- R5: `depth_mode` is control bits 3:1, `be_bytes` is control bit 9 and `be_pixels` is control bit 10.
- R6: `resize_pulse` is high for one cycle after either of two kinds of write. The first is a timing0 or timing1 write that changes `cols` or `rows` while `disp_en` is 1. The second is a control write whose value enables the display. No other write raises it.
- R7: Index 8 reads the raw status and index 9 reads raw AND mask. `irq_out` is the OR of the masked status.
- R8: A 1 on `irq_events[i]` sets raw bit i. A write to index 10 clears each raw bit written as 1. When a set and a clear hit the same bit in the same cycle, the set wins.
- R9: Index 11 reads the upper base and index 12 reads the lower base.
- R10: Any other access returns 0 and changes no register. This covers a read of index 10, a write to a read-only index and any unmapped index. Such an access sets `access_err`, which stays set until reset.
- R11: After reset every register is zero. `disp_en`, `irq_out` and `access_err` read 0, `cols` reads 16 and `rows` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_events | input | 4 | Single-cycle interrupt event inputs |
| irq_out | output | 1 | Combined interrupt request |
| disp_en | output | 1 | Display enabled (enable and power) |
| cols | output | 11 | Pixels per line |
| rows | output | 11 | Lines per panel |
| depth_mode | output | 3 | Pixel depth select |
| be_bytes | output | 1 | Big-endian byte order select |
| be_pixels | output | 1 | Big-endian pixel order within a byte |
| resize_pulse | output | 1 | One-cycle geometry change strobe |
| access_err | output | 1 | Sticky illegal-access flag |

## Verification
The register outputs `disp_en`, `cols`, `rows`, `depth_mode` and the ordering selects reflect a write in the cycle after the write edge. `resize_pulse` is high only in that same cycle. Read data appears one edge after `rd_en`. Interrupt events and clears reach `irq_out` and the status words one edge later. The bench drives every strobe on the falling edge and samples on the next falling edge, so each result is read exactly one edge after its cause. The pulse is also checked to be low again on the edge after that.

// File: rtl/lcdc_regs_pkg.sv
package lcdc_regs_pkg;
    localparam int AW    = 12;
    localparam int DW    = 32;
    localparam int NIRQ  = 4;
    localparam int COL_W = 11;
    localparam int ROW_W = 11;
    localparam int IDX_W = AW - 2;

    localparam logic [IDX_W-1:0] IX_TIM0 = 10'd0;
    localparam logic [IDX_W-1:0] IX_TIM1 = 10'd1;
    localparam logic [IDX_W-1:0] IX_TIM3 = 10'd3;
    localparam logic [IDX_W-1:0] IX_UBAS = 10'd4;
    localparam logic [IDX_W-1:0] IX_LBAS = 10'd5;
    localparam logic [IDX_W-1:0] IX_MASK = 10'd6;
    localparam logic [IDX_W-1:0] IX_CTRL = 10'd7;
    localparam logic [IDX_W-1:0] IX_RAW  = 10'd8;
    localparam logic [IDX_W-1:0] IX_MSKD = 10'd9;
    localparam logic [IDX_W-1:0] IX_CLR  = 10'd10;
    localparam logic [IDX_W-1:0] IX_UCUR = 10'd11;
    localparam logic [IDX_W-1:0] IX_LCUR = 10'd12;
    localparam logic [IDX_W-1:0] IX_ID0  = 10'h3F8;

    localparam int C_EN   = 0;
    localparam int C_PWR  = 11;
    localparam int C_BEB  = 9;
    localparam int C_BEP  = 10;

    typedef struct packed {
        logic [COL_W-1:0] cols;
        logic [ROW_W-1:0] rows;
    } geom_t;

    function automatic geom_t decode_geom(input logic [DW-1:0] t0, input logic [DW-1:0] t1);
        geom_t g;
        logic [COL_W-1:0] units;
        units  = COL_W'(t0[7:2]) + COL_W'(1);
        g.cols = units << 4;
        g.rows = ROW_W'(t1[9:0]) + ROW_W'(1);
        return g;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] k);
        case (k)
            3'd0: id_byte = 8'h10;
            3'd1: id_byte = 8'h11;
            3'd2: id_byte = 8'h04;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/lcdc_idrom.sv
module lcdc_idrom
    import lcdc_regs_pkg::*;
(
    input  logic [2:0] sel,
    output logic [7:0] id_val
);
    always_comb id_val = id_byte(sel);
endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq
    import lcdc_regs_pkg::*;
#(
    parameter int N = NIRQ
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] events,
    input  logic         mask_we,
    input  logic         clr_we,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] raw_q,
    output logic [N-1:0] masked,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                raw_q[i] <= 1'b0;
            else if (events[i])
                raw_q[i] <= 1'b1;
            else if (clr_we && wbits[i])
                raw_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (mask_we)
            mask_q <= wbits;
    end

    always_comb begin
        masked = raw_q & mask_q;
        irq    = |masked;
    end
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
    import lcdc_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] tim0,
    input  logic [DW-1:0] tim1,
    input  logic [DW-1:0] wdata,
    input  logic          tim0_we,
    input  logic          tim1_we,
    input  logic          ctrl_we,
    input  logic          en_now,
    output geom_t         geom,
    output logic          resize
);
    geom_t g_t0, g_t1;

    always_comb begin
        geom = decode_geom(tim0, tim1);
        g_t0 = decode_geom(wdata, tim1);
        g_t1 = decode_geom(tim0, wdata);
    end

    always_ff @(posedge clk) begin
        if (rst)
            resize <= 1'b0;
        else
            resize <= (tim0_we && en_now && (g_t0.cols != geom.cols)) ||
                      (tim1_we && en_now && (g_t1.rows != geom.rows)) ||
                      (ctrl_we && wdata[C_EN] && wdata[C_PWR]);
    end
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
    import lcdc_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NIRQ-1:0]   irq_events,
    output logic              irq_out,
    output logic              disp_en,
    output logic [COL_W-1:0]  cols,
    output logic [ROW_W-1:0]  rows,
    output logic [2:0]        depth_mode,
    output logic              be_bytes,
    output logic              be_pixels,
    output logic              resize_pulse,
    output logic              access_err
);
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    tim_q [4];
    logic [DW-1:0]    ubase_q, lbase_q, ctrl_q;
    logic [NIRQ-1:0]  irq_mask, irq_raw, irq_masked;
    logic             is_id, wr_ok, rd_ok;
    logic [7:0]       id_val;
    logic [DW-1:0]    rd_mux;
    geom_t            geom;

    assign idx   = addr[AW-1:2];
    assign is_id = (idx >= IX_ID0);
    assign wr_ok = (idx <= IX_CTRL) || (idx == IX_CLR);
    assign rd_ok = is_id || (idx <= IX_MSKD) || (idx == IX_UCUR) || (idx == IX_LCUR);

    for (genvar t = 0; t < 4; t++) begin : g_tim
        always_ff @(posedge clk) begin
            if (rst)
                tim_q[t] <= '0;
            else if (wr_en && idx == IX_TIM0 + IDX_W'(t))
                tim_q[t] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ubase_q    <= '0;
            lbase_q    <= '0;
            ctrl_q     <= '0;
            access_err <= 1'b0;
            rdata      <= '0;
        end else begin
            if (wr_en && idx == IX_UBAS) ubase_q <= wdata;
            if (wr_en && idx == IX_LBAS) lbase_q <= wdata;
            if (wr_en && idx == IX_CTRL) ctrl_q  <= wdata;
            if ((wr_en && !wr_ok) || (rd_en && !rd_ok))
                access_err <= 1'b1;
            if (rd_en)
                rdata <= rd_mux;
        end
    end

    lcdc_idrom u_id (
        .sel    (idx[2:0]),
        .id_val (id_val)
    );

    lcdc_irq #(.N(NIRQ)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .events  (irq_events),
        .mask_we (wr_en && idx == IX_MASK),
        .clr_we  (wr_en && idx == IX_CLR),
        .wbits   (wdata[NIRQ-1:0]),
        .mask_q  (irq_mask),
        .raw_q   (irq_raw),
        .masked  (irq_masked),
        .irq     (irq_out)
    );

    lcdc_geom u_geom (
        .clk     (clk),
        .rst     (rst),
        .tim0    (tim_q[0]),
        .tim1    (tim_q[1]),
        .wdata   (wdata),
        .tim0_we (wr_en && idx == IX_TIM0),
        .tim1_we (wr_en && idx == IX_TIM1),
        .ctrl_we (wr_en && idx == IX_CTRL),
        .en_now  (disp_en),
        .geom    (geom),
        .resize  (resize_pulse)
    );

    always_comb begin
        rd_mux = '0;
        if (is_id)
            rd_mux = DW'(id_val);
        else if (idx <= IX_TIM3)
            rd_mux = tim_q[idx[1:0]];
        else begin
            case (idx)
                IX_UBAS, IX_UCUR: rd_mux = ubase_q;
                IX_LBAS, IX_LCUR: rd_mux = lbase_q;
                IX_MASK:          rd_mux = DW'(irq_mask);
                IX_CTRL:          rd_mux = ctrl_q;
                IX_RAW:           rd_mux = DW'(irq_raw);
                IX_MSKD:          rd_mux = DW'(irq_masked);
                default:          rd_mux = '0;
            endcase
        end
    end

    always_comb begin
        disp_en    = ctrl_q[C_EN] && ctrl_q[C_PWR];
        depth_mode = ctrl_q[3:1];
        be_bytes   = ctrl_q[C_BEB];
        be_pixels  = ctrl_q[C_BEP];
        cols       = geom.cols;
        rows       = geom.rows;
    end
endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk
    import lcdc_regs_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [AW-1:0]   addr,
    input logic [NIRQ-1:0] irq_events,
    input logic [NIRQ-1:0] raw_q,
    input logic            disp_en,
    input logic            irq_out,
    input logic            resize_pulse,
    input logic            access_err
);
    a_r3_enable_from_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_en) |-> $past(wr_en && addr[AW-1:2] == IX_CTRL));

    a_r6_resize_needs_write: assert property (@(posedge clk) disable iff (rst)
        resize_pulse |-> $past(wr_en));

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (irq_events != '0) |=> (raw_q != '0));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        access_err |=> access_err);

    a_r11_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!disp_en && !irq_out && !access_err && !resize_pulse));
endmodule

bind lcdc_regs lcdc_regs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .addr         (addr),
    .irq_events   (irq_events),
    .raw_q        (irq_raw),
    .disp_en      (disp_en),
    .irq_out      (irq_out),
    .resize_pulse (resize_pulse),
    .access_err   (access_err)
);

// File: tb/lcdc_regs_tb.sv
module lcdc_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq_events = '0;
    logic        irq_out, disp_en, be_bytes, be_pixels, resize_pulse, access_err;
    logic [10:0] cols, rows;
    logic [2:0]  depth_mode;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lcdc_regs u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_events(irq_events), .irq_out(irq_out),
        .disp_en(disp_en), .cols(cols), .rows(rows), .depth_mode(depth_mode),
        .be_bytes(be_bytes), .be_pixels(be_pixels), .resize_pulse(resize_pulse),
        .access_err(access_err)
    );

    function automatic logic [10:0] exp_cols(input logic [31:0] t0);
        return 11'(16 * (((t0 >> 2) & 32'h3F) + 1));
    endfunction
    function automatic logic [10:0] exp_rows(input logic [31:0] t1);
        return 11'((t1 & 32'h3FF) + 1);
    endfunction
    function automatic logic [31:0] exp_id(input int k);
        logic [7:0] tbl [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return {24'h0, tbl[k]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic ev(input logic [3:0] e, input bit do_clr, input logic [3:0] c);
        @(negedge clk);
        irq_events = e;
        if (do_clr) begin wr_en = 1'b1; addr = 12'h028; wdata = {28'h0, c}; end
        @(negedge clk);
        irq_events = '0; wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, t0, t1, u, l;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(disp_en == 0 && irq_out == 0 && access_err == 0, "R11", {disp_en, irq_out, access_err}, 0);
        chk(cols == 16 && rows == 1, "R11", {cols, 5'd0, rows}, {11'd16, 5'd0, 11'd1});
        rd(12'h01C, d); chk(d == 0, "R11", d, 0);

        // R2 identification bytes
        for (int k = 0; k < 8; k++) begin
            rd(12'hFE0 + 12'(k * 4), d);
            chk(d == exp_id(k), "R2", d, exp_id(k));
        end

        // R1 R4 R6 random timing words, display disabled
        for (int n = 0; n < 20; n++) begin
            t0 = $urandom; t1 = $urandom;
            wr(12'h000, t0);
            chk(resize_pulse == 0, "R6", resize_pulse, 0);
            wr(12'h004, t1);
            chk(cols == exp_cols(t0) && rows == exp_rows(t1), "R4",
                {cols, 5'd0, rows}, {exp_cols(t0), 5'd0, exp_rows(t1)});
            rd(12'h000, d); chk(d == t0, "R1", d, t0);
            rd(12'h004, d); chk(d == t1, "R1", d, t1);
        end
        for (int k = 2; k < 4; k++) begin
            d = $urandom; t0 = d;
            wr(12'(k * 4), t0);
            rd(12'(k * 4), d); chk(d == t0, "R1", d, t0);
        end
        // R4 boundary fields
        wr(12'h000, 32'hFFFF_FFFC); wr(12'h004, 32'h0000_03FF);
        chk(cols == 1024 && rows == 1024, "R4", {cols, 5'd0, rows}, {11'd1024, 5'd0, 11'd1024});
        wr(12'h000, 32'h0000_0003); wr(12'h004, 32'hFFFF_FC00);
        chk(cols == 16 && rows == 1, "R4", {cols, 5'd0, rows}, {11'd16, 5'd0, 11'd1});

        // R3 enable gating
        wr(12'h01C, 32'h0000_0001); chk(disp_en == 0, "R3", disp_en, 0);
        chk(resize_pulse == 0, "R6", resize_pulse, 0);
        wr(12'h01C, 32'h0000_0800); chk(disp_en == 0, "R3", disp_en, 0);
        // R5 mode fields, R6 enabling control write
        wr(12'h01C, 32'h0000_0A0B);
        chk(disp_en == 1, "R3", disp_en, 1);
        chk(resize_pulse == 1, "R6", resize_pulse, 1);
        chk(depth_mode == 3'd5 && be_bytes == 1 && be_pixels == 0, "R5",
            {depth_mode, be_bytes, be_pixels}, {3'd5, 1'b1, 1'b0});
        @(negedge clk); chk(resize_pulse == 0, "R6", resize_pulse, 0);
        wr(12'h01C, 32'h0000_0C03);
        chk(depth_mode == 3'd1 && be_bytes == 0 && be_pixels == 1, "R5",
            {depth_mode, be_bytes, be_pixels}, {3'd1, 1'b0, 1'b1});

        // R6 geometry changes while enabled
        wr(12'h000, 32'h0000_0010); chk(resize_pulse == 1, "R6", resize_pulse, 1);
        wr(12'h000, 32'h0000_0013); chk(resize_pulse == 0, "R6", resize_pulse, 0);
        wr(12'h004, 32'h0000_00EF); chk(resize_pulse == 1, "R6", resize_pulse, 1);
        wr(12'h004, 32'h0000_04EF); chk(resize_pulse == 0, "R6", resize_pulse, 0);

        // R1 R9 base and current address
        u = $urandom; l = $urandom;
        wr(12'h010, u); wr(12'h014, l);
        rd(12'h010, d); chk(d == u, "R1", d, u);
        rd(12'h014, d); chk(d == l, "R1", d, l);
        rd(12'h02C, d); chk(d == u, "R9", d, u);
        rd(12'h030, d); chk(d == l, "R9", d, l);

        // R7 R8 interrupts
        wr(12'h018, 32'hFFFF_FFF5);
        rd(12'h018, d); chk(d == 32'h5, "R1", d, 32'h5);
        ev(4'hF, 0, 4'h0);
        chk(irq_out == 1, "R7", irq_out, 1);
        rd(12'h020, d); chk(d == 32'hF, "R7", d, 32'hF);
        rd(12'h024, d); chk(d == 32'h5, "R7", d, 32'h5);
        wr(12'h028, 32'h5);
        chk(irq_out == 0, "R8", irq_out, 0);
        rd(12'h020, d); chk(d == 32'hA, "R8", d, 32'hA);
        ev(4'h2, 1, 4'hA);
        rd(12'h020, d); chk(d == 32'h2, "R8", d, 32'h2);
        chk(irq_out == 0, "R7", irq_out, 0);
        wr(12'h018, 32'h2);
        chk(irq_out == 1, "R7", irq_out, 1);

        // R10 illegal accesses
        chk(access_err == 0, "R10", access_err, 0);
        rd(12'h028, d); chk(d == 0, "R10", d, 0);
        chk(access_err == 1, "R10", access_err, 1);
        wr(12'h040, 32'hDEAD_BEEF);
        rd(12'h040, d); chk(d == 0, "R10", d, 0);
        wr(12'h020, 32'hF);
        rd(12'h020, d); chk(d == 32'h2, "R10", d, 32'h2);
        wr(12'h02C, 32'h1234_5678);
        rd(12'h010, d); chk(d == u, "R10", d, u);
        chk(access_err == 1, "R10", access_err, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule